// File: doc/BRIEF.md
# Cartridge Tape Controller Register File

This block is the set of host-visible registers of a cartridge tape controller that sits on a 16-bit peripheral I/O bus. The host selects the block with a 4-bit peripheral address and picks one of four registers with a 2-bit register select. The four registers are a status word of drive sense lines, a control word, an event counter and a data checksum. A write to the control word launches a tape command. The command's fields go out to the drive sequencer.

The controller models a command as a counted move. The counter advances on tachometer pulses or on gap detections, depending on the command code. When it rolls over from all ones to zero, the command ends: the busy flag drops and a one-cycle interrupt request is raised. The host can preload the counter, which also freezes it until the next command starts. The checksum keeps a running modulo-65536 sum of every data word moved to or from the tape. Reading it returns the sum and clears it. Writing at the checksum select instead loads a separate configuration word.

Top module: `tape_ctl_regs`

## Requirements
- R1: The block responds only when `pa_addr` equals 12. At any other address a read returns 0 and a write changes no register.
- R2: `reg_sel` picks the register: 0 = status, 1 = control, 2 = counter, 3 = checksum (read) / configuration (write).
- R3: Status read layout:
  - bit 0: hole detect
  - bit 1: cartridge out
  - bit 2: servo fail
  - bit 3: write protect
  - bit 4: in-gap
  - bit 5: track B
  - bit 15: busy flag
  - all other bits read 0
- R4: Control write fields and their effects:
  - bits 14..10: command code, driven on `cmd_code`
  - bit 6: modifier, driven on `cmd_modifier`
  - bit 7: fast speed, driven on `cmd_fast`
  - bit 8: long minimum gap, driven on `cmd_long_gap`
  - bit 9: auto stop, driven on `cmd_auto_stop`
  - the field outputs update in the cycle after the write
  - `cmd_start` is high for exactly that one cycle
  - a control read returns bits 14..6 of the last write, with all other bits 0
- R5: A control write with a nonzero code sets busy. Code bit 0 selects the counted event: 1 counts `gap_evt`, 0 counts `tach_evt`. The other event input is ignored.
- R6: While busy and not frozen, the counter increments by one in each cycle that has the selected event. A counter read returns its value.
- R7: An event with the counter at 0xFFFF wraps it to 0 and clears busy. `irq` is then high for exactly the next cycle.
- R8: A counter write loads the written value and freezes counting until the next command start. The start resumes counting from the loaded value.
- R9: Control code 0 is clear-errors. It clears busy, raises no `irq`, and does not start counting.
- R10: A checksum read returns the modulo-65536 sum of all `xfer_word` values taken with `xfer_valid` since the previous checksum read, or since reset, and clears the sum.
- R11: A checksum read in the same cycle as a transfer returns the old sum. The new sum then equals that transferred word.
- R12: A write at select 3 loads `cfg_word` in the next cycle and leaves the checksum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_addr | input | 4 | Peripheral address |
| reg_sel | input | 2 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational while reading) |
| drv_sense | input | 6 | Drive sense lines, status bits 5..0 |
| tach_evt | input | 1 | Tachometer pulse, one per cycle |
| gap_evt | input | 1 | Gap detection, one per cycle |
| xfer_valid | input | 1 | Data word moved to or from tape this cycle |
| xfer_word | input | 16 | Transferred data word |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_code | output | 5 | Current command code |
| cmd_modifier | output | 1 | Command-dependent modifier |
| cmd_fast | output | 1 | Fast speed select |
| cmd_long_gap | output | 1 | Long minimum gap select |
| cmd_auto_stop | output | 1 | Stop automatically when the command completes |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Command-complete interrupt pulse |
| cfg_word | output | 16 | Configuration word |

## Verification
A checksum read and an incoming data transfer can fall in the same clock cycle. In that cycle the clear and the addition must merge, not lose one of the two. The bench raises the checksum read strobe and `xfer_valid` together on one cycle. It samples the returned word during that cycle and expects the sum of the earlier words. It then reads again and expects exactly the word that arrived with the first read. It also loads a counter value and starts a command in separate cycles, to confirm that the freeze holds until the start.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int DATA_W  = 16;
    localparam int CODE_W  = 5;
    localparam int SENSE_W = 6;
    localparam int NREG    = 4;
    localparam int SEL_W   = $clog2(NREG);

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_CSUM   = 2'd3
    } reg_sel_e;

    // ordered so that it maps onto control bits 14..6
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              auto_stop;
        logic              long_gap;
        logic              fast;
        logic              modifier;
    } ctrl_word_t;

    localparam int CTRL_LSB = 6;
    localparam int CTRL_W   = $bits(ctrl_word_t);
    localparam logic [CODE_W-1:0] CODE_CLR_ERR = '0;

    function automatic ctrl_word_t unpack_ctrl(input logic [DATA_W-1:0] w);
        return ctrl_word_t'(w[CTRL_LSB +: CTRL_W]);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_word_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_LSB +: CTRL_W] = c;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [SENSE_W-1:0] s,
                                                      input logic busy_f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SENSE_W-1:0] = s;
        w[DATA_W-1]    = busy_f;
        return w;
    endfunction
endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
    import tcr_pkg::*;
#(
    parameter int PA_W     = 4,
    parameter int DEV_ADDR = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PA_W-1:0]  pa_addr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    output logic             hit,
    output logic [NREG-1:0]  rd_strb,
    output logic [NREG-1:0]  wr_strb
);
    assign hit = (pa_addr == PA_W'(DEV_ADDR));

    for (genvar i = 0; i < NREG; i++) begin : g_strb
        assign rd_strb[i] = hit && rd_en && (reg_sel == SEL_W'(i));
        assign wr_strb[i] = hit && wr_en && (reg_sel == SEL_W'(i));
    end

    a_r2_rd_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_strb));
    a_r2_wr_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_strb));
endmodule

// File: rtl/tcr_cmd.sv
module tcr_cmd
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tach_evt,
    input  logic              gap_evt,
    output ctrl_word_t        ctrl,
    output logic              cmd_start,
    output logic              busy,
    output logic              irq,
    output logic [DATA_W-1:0] count
);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;

    ctrl_word_t wr_fields;
    logic       start_now, clr_now, frozen, src_gap, sel_evt, counting;

    assign wr_fields = unpack_ctrl(wdata);
    assign start_now = wr_ctrl && (wr_fields.code != CODE_CLR_ERR);
    assign clr_now   = wr_ctrl && (wr_fields.code == CODE_CLR_ERR);
    assign sel_evt   = src_gap ? gap_evt : tach_evt;
    assign counting  = busy && !frozen && !wr_ctrl && !wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            cmd_start <= 1'b0;
            busy      <= 1'b0;
            irq       <= 1'b0;
            count     <= '0;
            frozen    <= 1'b0;
            src_gap   <= 1'b0;
        end else begin
            cmd_start <= start_now;
            irq       <= 1'b0;
            if (wr_ctrl) ctrl <= wr_fields;
            if (start_now) begin
                busy    <= 1'b1;
                frozen  <= 1'b0;
                src_gap <= wr_fields.code[0];
            end else if (clr_now) begin
                busy <= 1'b0;
            end
            if (wr_cnt) begin
                count  <= wdata;
                frozen <= 1'b1;
            end else if (counting && sel_evt) begin
                count <= count + 1'b1;
                if (count == CNT_MAX) begin
                    busy <= 1'b0;
                    irq  <= 1'b1;
                end
            end
        end
    end

    a_r7_rollover_ends: assert property (@(posedge clk) disable iff (rst)
        (counting && sel_evt && count == CNT_MAX) |=> (!busy && irq && count == '0));
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    a_r7_irq_idle: assert property (@(posedge clk) disable iff (rst) irq |-> !busy);
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_cnt && !wr_ctrl) |=> $stable(count));
    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> (!busy && !irq));
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> busy);
endmodule

// File: rtl/tcr_csum.sv
module tcr_csum
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_csum,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xfer_valid,
    input  logic [DATA_W-1:0] xfer_word,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] cfg_word
);
    logic [DATA_W-1:0] base, addend;

    assign base   = rd_csum ? '0 : sum;
    assign addend = xfer_valid ? xfer_word : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum      <= '0;
            cfg_word <= '0;
        end else begin
            sum <= base + addend;
            if (wr_cfg) cfg_word <= wdata;
        end
    end

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_csum && !xfer_valid) |=> (sum == '0));
    a_r11_read_and_add: assert property (@(posedge clk) disable iff (rst)
        (rd_csum && xfer_valid) |=> (sum == $past(xfer_word)));
    a_r12_cfg_no_touch: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !rd_csum && !xfer_valid) |=> $stable(sum));
endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
    import tcr_pkg::*;
#(
    parameter int PA_W     = 4,
    parameter int DEV_ADDR = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PA_W-1:0]    pa_addr,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [SENSE_W-1:0] drv_sense,
    input  logic               tach_evt,
    input  logic               gap_evt,
    input  logic               xfer_valid,
    input  logic [DATA_W-1:0]  xfer_word,
    output logic               cmd_start,
    output logic [CODE_W-1:0]  cmd_code,
    output logic               cmd_modifier,
    output logic               cmd_fast,
    output logic               cmd_long_gap,
    output logic               cmd_auto_stop,
    output logic               busy,
    output logic               irq,
    output logic [DATA_W-1:0]  cfg_word
);
    logic              hit;
    logic [NREG-1:0]   rd_strb, wr_strb;
    ctrl_word_t        ctrl;
    logic [DATA_W-1:0] count, sum;

    tcr_decode #(.PA_W(PA_W), .DEV_ADDR(DEV_ADDR)) u_dec (
        .clk(clk), .rst(rst), .pa_addr(pa_addr), .reg_sel(reg_sel),
        .rd_en(rd_en), .wr_en(wr_en), .hit(hit),
        .rd_strb(rd_strb), .wr_strb(wr_strb)
    );

    tcr_cmd u_cmd (
        .clk(clk), .rst(rst),
        .wr_ctrl(wr_strb[SEL_CTRL]), .wr_cnt(wr_strb[SEL_COUNT]),
        .wdata(wdata), .tach_evt(tach_evt), .gap_evt(gap_evt),
        .ctrl(ctrl), .cmd_start(cmd_start), .busy(busy), .irq(irq), .count(count)
    );

    tcr_csum u_csum (
        .clk(clk), .rst(rst),
        .rd_csum(rd_strb[SEL_CSUM]), .wr_cfg(wr_strb[SEL_CSUM]), .wdata(wdata),
        .xfer_valid(xfer_valid), .xfer_word(xfer_word),
        .sum(sum), .cfg_word(cfg_word)
    );

    assign cmd_code      = ctrl.code;
    assign cmd_modifier  = ctrl.modifier;
    assign cmd_fast      = ctrl.fast;
    assign cmd_long_gap  = ctrl.long_gap;
    assign cmd_auto_stop = ctrl.auto_stop;

    always_comb begin
        rdata = '0;
        unique case (1'b1)
            rd_strb[SEL_STATUS]: rdata = pack_status(drv_sense, busy);
            rd_strb[SEL_CTRL]:   rdata = pack_ctrl(ctrl);
            rd_strb[SEL_COUNT]:  rdata = count;
            rd_strb[SEL_CSUM]:   rdata = sum;
            default:             rdata = '0;
        endcase
    end

    a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (!hit && rd_en) |-> (rdata == '0));
    a_r1_miss_holds_cfg: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cfg_word));
endmodule

// File: tb/tape_ctl_regs_tb.sv
module tape_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pa_addr = 4'd0;
    logic [1:0]  reg_sel = 2'd0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic [5:0]  drv_sense = '0;
    logic        tach_evt = 1'b0, gap_evt = 1'b0, xfer_valid = 1'b0;
    logic [15:0] xfer_word = '0;
    logic        cmd_start, cmd_modifier, cmd_fast, cmd_long_gap, cmd_auto_stop, busy, irq;
    logic [4:0]  cmd_code;
    logic [15:0] cfg_word;

    int n_vec = 0, n_bad = 0;

    tape_ctl_regs u_dut (
        .clk(clk), .rst(rst), .pa_addr(pa_addr), .reg_sel(reg_sel),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .drv_sense(drv_sense), .tach_evt(tach_evt), .gap_evt(gap_evt),
        .xfer_valid(xfer_valid), .xfer_word(xfer_word),
        .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_modifier(cmd_modifier),
        .cmd_fast(cmd_fast), .cmd_long_gap(cmd_long_gap), .cmd_auto_stop(cmd_auto_stop),
        .busy(busy), .irq(irq), .cfg_word(cfg_word)
    );

    always #5 clk = ~clk;

    localparam logic [3:0] DEV = 4'd12;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        pa_addr = a; reg_sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        pa_addr = a; reg_sel = s; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulses(input bit use_gap, input int n);
        @(negedge clk);
        if (use_gap) gap_evt = 1'b1; else tach_evt = 1'b1;
        repeat (n) @(negedge clk);
        gap_evt = 1'b0; tach_evt = 1'b0;
    endtask

    task automatic xfer(input logic [15:0] w);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_word = w;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d, exp_cnt, sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        bus_rd(DEV, 2'd2, d); check("R6 reset counter", d, 16'h0);
        bus_rd(DEV, 2'd3, d); check("R10 reset checksum", d, 16'h0);
        check("R7 reset busy/irq", {14'd0, busy, irq}, 16'h0);

        // R3 status sweep over every sense pattern
        for (int s = 0; s < 64; s++) begin
            drv_sense = 6'(s);
            bus_rd(DEV, 2'd0, d);
            check("R3 status layout", d, 16'(s));
        end

        // R1 address sweep: writes and reads at each peripheral address
        exp_cnt = 16'h0;
        for (int a = 0; a < 16; a++) begin
            bus_wr(4'(a), 2'd2, 16'h1000 + 16'(a));
            if (a == 12) exp_cnt = 16'h100C;
            bus_rd(4'(a), 2'd2, d);
            check("R1 read at address", d, (a == 12) ? exp_cnt : 16'h0);
            bus_rd(DEV, 2'd2, d);
            check("R1 write at address", d, exp_cnt);
        end

        // R4 control fields for every nonzero code, R5 busy set
        for (int c = 1; c < 32; c++) begin
            logic [15:0] w;
            w = {1'b1, 5'(c), 4'(c * 7), 6'h2B};
            bus_wr(DEV, 2'd1, w);
            check("R4 cmd_start pulse", {15'd0, cmd_start}, 16'h1);
            check("R4 field outputs",
                  {7'd0, cmd_code, cmd_auto_stop, cmd_long_gap, cmd_fast, cmd_modifier},
                  {7'd0, 5'(c), 4'(c * 7)});
            check("R5 busy set", {15'd0, busy}, 16'h1);
            bus_rd(DEV, 2'd1, d);
            check("R4 control readback", d, w & 16'h7FC0);
            check("R4 pulse is single", {15'd0, cmd_start}, 16'h0);
        end
        bus_wr(DEV, 2'd1, 16'h0040);
        check("R9 clear-errors busy", {14'd0, busy, irq}, 16'h0);
        check("R9 clear no start", {15'd0, cmd_start}, 16'h0);

        // R5/R6/R7 tach-counted command with rollover
        bus_wr(DEV, 2'd2, 16'hFFF0);
        bus_wr(DEV, 2'd1, {1'b0, 5'd2, 10'd0});
        pulses(1'b1, 5);
        bus_rd(DEV, 2'd2, d); check("R5 gap ignored on tach cmd", d, 16'hFFF0);
        pulses(1'b0, 15);
        bus_rd(DEV, 2'd2, d); check("R6 counted tach", d, 16'hFFFF);
        bus_rd(DEV, 2'd0, d); check("R3 busy bit", d & 16'h8000, 16'h8000);
        pulses(1'b0, 1);
        check("R7 rollover busy/irq", {14'd0, busy, irq}, 16'h1);
        @(negedge clk);
        check("R7 irq one cycle", {15'd0, irq}, 16'h0);
        bus_rd(DEV, 2'd2, d); check("R7 counter wrapped", d, 16'h0);
        pulses(1'b0, 3);
        bus_rd(DEV, 2'd2, d); check("R6 idle no count", d, 16'h0);

        // gap-counted command
        bus_wr(DEV, 2'd2, 16'hFFFD);
        bus_wr(DEV, 2'd1, {1'b0, 5'd3, 10'd0});
        pulses(1'b0, 4);
        bus_rd(DEV, 2'd2, d); check("R5 tach ignored on gap cmd", d, 16'hFFFD);
        pulses(1'b1, 3);
        check("R7 gap rollover", {14'd0, busy, irq}, 16'h1);

        // R8 freeze by counter write, resume at next start
        bus_wr(DEV, 2'd2, 16'h0100);
        bus_wr(DEV, 2'd1, {1'b0, 5'd2, 10'd0});
        pulses(1'b0, 3);
        bus_rd(DEV, 2'd2, d); check("R8 counting resumed", d, 16'h0103);
        bus_wr(DEV, 2'd2, 16'h0200);
        pulses(1'b0, 5);
        bus_rd(DEV, 2'd2, d); check("R8 frozen", d, 16'h0200);
        check("R8 still busy", {15'd0, busy}, 16'h1);
        bus_wr(DEV, 2'd1, {1'b0, 5'd2, 10'd0});
        pulses(1'b0, 2);
        bus_rd(DEV, 2'd2, d); check("R8 restart resumes", d, 16'h0202);
        bus_wr(DEV, 2'd1, 16'h0000);
        check("R9 abort", {14'd0, busy, irq}, 16'h0);
        pulses(1'b0, 3);
        bus_rd(DEV, 2'd2, d); check("R9 no count after clear", d, 16'h0202);

        // R10 checksum accumulation with wrap
        sum = 16'h0;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] w;
            w = 16'(i * 16'h1357 + 16'hF00D);
            xfer(w);
            sum = sum + w;
        end
        bus_rd(DEV, 2'd3, d); check("R10 checksum sum", d, sum);
        bus_rd(DEV, 2'd3, d); check("R10 cleared on read", d, 16'h0);

        // R11 read coinciding with transfer
        xfer(16'h1111); xfer(16'h2222);
        @(negedge clk);
        pa_addr = DEV; reg_sel = 2'd3; rd_en = 1'b1;
        xfer_valid = 1'b1; xfer_word = 16'hABCD;
        #1 d = rdata;
        check("R11 old sum returned", d, 16'h3333);
        @(negedge clk);
        rd_en = 1'b0; xfer_valid = 1'b0;
        bus_rd(DEV, 2'd3, d); check("R11 new sum is word", d, 16'hABCD);

        // R12 configuration write
        xfer(16'h0011);
        bus_wr(DEV, 2'd3, 16'h5A5A);
        check("R12 cfg loaded", cfg_word, 16'h5A5A);
        bus_wr(4'd3, 2'd3, 16'h0F0F);
        check("R1 cfg miss ignored", cfg_word, 16'h5A5A);
        bus_rd(DEV, 2'd3, d); check("R12 checksum kept", d, 16'h0011);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule